// File: doc/BRIEF.md
# Grouped Event Selector with Column Exclusion

This block steers raw event lines onto a set of general event counters. The raw events form a grid: eight groups (columns), each holding a number of codes (rows). A 64-bit residency register keeps one 8-bit code per group, so each group has exactly one code live at a time. Each general counter has a small type register that names a group. A counter's increment pulse is the raw event found at the code chosen for that group, in that group's column. A global enable bit in the residency register gates every pulse.

Beside the steering logic sits an allocator. It takes 12-bit event identifiers (code in bits [11:4], group in bits [3:0]) and hands out counter indices. A general request gets the lowest free general counter. It is refused if its group is already held or if every general counter is busy. The special identifier 0xFE asks for the one dedicated cycle counter, which sits outside the group grid. Releasing an index frees it again, together with its group. Counting itself is done elsewhere.

Top module: `grp_evt_sel`

## Requirements
- R1: After reset the residency register and all type registers read zero, no response is valid and every increment pulse is low.
- R2: A residency write for group g replaces bits [8g+7:8g] with the written code, leaves every other group's field unchanged, and sets bit 63 (the global enable); the new value is visible on the next cycle. Without a write the register holds its value.
- R3: Increment pulse i equals the raw input at position code*8+g, where g is the group in counter i's type register and code is group g's residency field. The pulse is forced low when bit 63 is clear, when g is above 7, or when code is not below NUM_CODES.
- R4: A valid general request is granted the lowest-numbered free general counter, indices 0 to NUM_GP-1.
- R5: A general request whose group is already held by an allocated general counter is rejected.
- R6: A general request is rejected when all general counters are busy.
- R7: Identifier 0xFE is granted index NUM_GP (the cycle counter) only if that counter is free, and it claims no group.
- R8: An identifier with any bit above bit 11 set, or with a group field above 7, is rejected unless it equals 0xFE.
- R9: A release of an allocated index frees that index and, for a general counter, its group. The release takes effect after any request made in the same cycle has been decided. A release of an index that is not allocated has no effect.
- R10: The response (valid, grant flag, index) appears exactly one cycle after the request. On a reject the index reads 0.
- R11: A type write to counter index k below NUM_GP loads its 4-bit group value, visible next cycle. A write with k of NUM_GP or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Residency field write strobe |
| sel_wr_grp | input | 3 | Group whose field is written |
| sel_wr_code | input | 8 | Code placed into the group field |
| sel_q | output | 64 | Residency register contents |
| typ_wr_en | input | 1 | Type register write strobe |
| typ_wr_idx | input | IDX_W | Counter whose type register is written |
| typ_wr_grp | input | 4 | Group value written |
| typ_q | output | 4*NUM_GP | All type registers, counter k in bits [4k+3:4k] |
| evt_raw | input | NUM_CODES*8 | Raw event grid, code c of group g at bit c*8+g |
| cnt_inc | output | NUM_GP | Per-counter increment pulse |
| req_valid | input | 1 | Allocation request strobe |
| req_id | input | ID_W | Requested event identifier |
| rel_valid | input | 1 | Release strobe |
| rel_idx | input | IDX_W | Index being released |
| rsp_valid | output | 1 | Allocation response valid |
| rsp_grant | output | 1 | Request granted |
| rsp_idx | output | IDX_W | Granted index |

## Verification
The hardest case to reach is a release and a request arriving in the same cycle. Here the freed group must not yet be visible to the request, and the freed index must not be overwritten. The bench reaches it by filling the counters so that the released counter's group is exactly the one being requested. It also drives the group-7 field, where the enable bit overlaps the top code bit, so that the stored code rises above NUM_CODES and the pulse must stay low. A behavioural model tracks the busy flags and group ownership, and every output is compared with it on every cycle.

// File: rtl/grp_evt_sel.sv
module grp_evt_sel #(
  parameter int NUM_GP    = 4,
  parameter int NUM_CODES = 16,
  parameter int ID_W      = 16,
  localparam int NUM_GRP  = 8,
  localparam int IDX_W    = $clog2(NUM_GP + 1),
  localparam int RAW_W    = NUM_CODES * NUM_GRP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_wr_en,
  input  logic [2:0]            sel_wr_grp,
  input  logic [7:0]            sel_wr_code,
  output logic [63:0]           sel_q,
  input  logic                  typ_wr_en,
  input  logic [IDX_W-1:0]      typ_wr_idx,
  input  logic [3:0]            typ_wr_grp,
  output logic [4*NUM_GP-1:0]   typ_q,
  input  logic [RAW_W-1:0]      evt_raw,
  output logic [NUM_GP-1:0]     cnt_inc,
  input  logic                  req_valid,
  input  logic [ID_W-1:0]       req_id,
  input  logic                  rel_valid,
  input  logic [IDX_W-1:0]      rel_idx,
  output logic                  rsp_valid,
  output logic                  rsp_grant,
  output logic [IDX_W-1:0]      rsp_idx
);
  localparam logic [ID_W-1:0] CYC_ID = ID_W'(8'hFE);

  logic [63:0]        sel_r;
  logic [3:0]         typ_r [NUM_GP];
  logic [NUM_GP:0]    busy;
  logic [NUM_GRP-1:0] grp_busy;
  logic [2:0]         own_grp [NUM_GP];

  assign sel_q = sel_r;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_r <= '0;
    else if (sel_wr_en)
      sel_r <= (sel_r & ~(64'hFF << (8 * sel_wr_grp)))
             | (64'(sel_wr_code) << (8 * sel_wr_grp))
             | 64'h8000_0000_0000_0000;
  end

  for (genvar i = 0; i < NUM_GP; i++) begin : g_ctr
    logic [7:0] code;
    int         pos;

    assign typ_q[4*i +: 4] = typ_r[i];
    assign code = sel_r[8*typ_r[i][2:0] +: 8];

    always_comb begin
      pos = int'(code) * NUM_GRP + int'(typ_r[i][2:0]);
      cnt_inc[i] = 1'b0;
      if (sel_r[63] && !typ_r[i][3] && int'(code) < NUM_CODES && pos < RAW_W)
        cnt_inc[i] = evt_raw[pos];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        typ_r[i] <= '0;
      else if (typ_wr_en && int'(typ_wr_idx) == i)
        typ_r[i] <= typ_wr_grp;
    end
  end

  logic [3:0]       id_grp;
  logic             is_cyc, id_ok, have_free, grant;
  logic [IDX_W-1:0] free_idx, gidx;

  assign id_grp = req_id[3:0];
  assign is_cyc = (req_id == CYC_ID);
  assign id_ok  = (req_id[ID_W-1:12] == '0) && !id_grp[3];

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int k = NUM_GP - 1; k >= 0; k--)
      if (!busy[k]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(k);
      end
  end

  always_comb begin
    grant = 1'b0;
    gidx  = '0;
    if (is_cyc) begin
      if (!busy[NUM_GP]) begin
        grant = 1'b1;
        gidx  = IDX_W'(NUM_GP);
      end
    end else if (id_ok && have_free && !grp_busy[id_grp[2:0]]) begin
      grant = 1'b1;
      gidx  = free_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      grp_busy  <= '0;
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_idx   <= '0;
      for (int k = 0; k < NUM_GP; k++) own_grp[k] <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && grant;
      rsp_idx   <= (req_valid && grant) ? gidx : '0;
      for (int k = 0; k <= NUM_GP; k++) begin
        if (rel_valid && int'(rel_idx) == k && busy[k]) begin
          busy[k] <= 1'b0;
          if (k < NUM_GP) grp_busy[own_grp[k]] <= 1'b0;
        end
      end
      if (req_valid && grant) begin
        busy[gidx] <= 1'b1;
        if (!is_cyc) begin
          grp_busy[id_grp[2:0]] <= 1'b1;
          for (int k = 0; k < NUM_GP; k++)
            if (int'(gidx) == k) own_grp[k] <= id_grp[2:0];
        end
      end
    end
  end
endmodule

// File: rtl/grp_evt_sel_chk.sv
module grp_evt_sel_chk #(
  parameter int NUM_GP = 4,
  parameter int ID_W   = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_wr_en,
  input logic [63:0]       sel_q,
  input logic [NUM_GP-1:0] cnt_inc,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_id,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [IDX_W-1:0]  rsp_idx
);
  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R10
  rej_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> rsp_idx == '0);
  // R2
  sel_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_en |=> sel_q[63]);
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_en |=> $stable(sel_q));
  // R3
  inc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q[63] |-> cnt_inc == '0);
  // R7
  cyc_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant && int'(rsp_idx) == NUM_GP) |-> $past(req_id) == ID_W'(8'hFE));
endmodule

bind grp_evt_sel grp_evt_sel_chk #(.NUM_GP(NUM_GP), .ID_W(ID_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_q(sel_q), .cnt_inc(cnt_inc),
  .req_valid(req_valid), .req_id(req_id), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_idx(rsp_idx)
);

// File: tb/tb_grp_evt_sel.sv
module tb_grp_evt_sel;
  localparam int NG = 4, NC = 16, IW = 16, XW = 3, RW = NC * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_wr_en = 0; logic [2:0] sel_wr_grp = 0; logic [7:0] sel_wr_code = 0;
  logic typ_wr_en = 0; logic [XW-1:0] typ_wr_idx = 0; logic [3:0] typ_wr_grp = 0;
  logic [RW-1:0] evt_raw = '0;
  logic req_valid = 0; logic [IW-1:0] req_id = 0;
  logic rel_valid = 0; logic [XW-1:0] rel_idx = 0;
  logic [63:0] sel_q; logic [4*NG-1:0] typ_q; logic [NG-1:0] cnt_inc;
  logic rsp_valid, rsp_grant; logic [XW-1:0] rsp_idx;

  int compared = 0, mismatched = 0;

  logic [63:0] m_sel; int m_typ[NG]; bit m_busy[NG+1]; bit m_gbusy[8]; int m_own[NG];
  bit m_rv, m_rg; int m_ri;

  always #5 clk = ~clk;

  grp_evt_sel #(.NUM_GP(NG), .NUM_CODES(NC), .ID_W(IW)) dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_inc();
    logic [NG-1:0] r = '0;
    for (int i = 0; i < NG; i++) begin
      int t = m_typ[i];
      if (m_sel[63] && t < 8) begin
        int c = int'((m_sel >> (t * 8)) & 64'hFF);
        if (c < NC) r[i] = evt_raw[c * 8 + t];
      end
    end
    return r;
  endfunction

  function automatic longint pack_typ();
    longint r = 0;
    for (int i = 0; i < NG; i++) r |= longint'(m_typ[i]) << (4 * i);
    return r;
  endfunction

  task automatic model_step();
    int g = int'(req_id[3:0]);
    bit ok, gr; int ix;
    gr = 0; ix = 0;
    if (req_valid) begin
      if (req_id == 16'h00FE) begin
        if (!m_busy[NG]) begin gr = 1; ix = NG; end
      end else begin
        ok = (req_id[15:12] == 0) && g < 8;
        if (ok && !m_gbusy[g])
          for (int k = NG - 1; k >= 0; k--) if (!m_busy[k]) begin gr = 1; ix = k; end
      end
    end
    if (rel_valid && int'(rel_idx) <= NG && m_busy[rel_idx]) begin
      m_busy[rel_idx] = 0;
      if (int'(rel_idx) < NG) m_gbusy[m_own[rel_idx]] = 0;
    end
    if (gr) begin
      m_busy[ix] = 1;
      if (ix < NG) begin m_gbusy[g] = 1; m_own[ix] = g; end
    end
    m_rv = req_valid; m_rg = gr; m_ri = ix;
    if (sel_wr_en) begin
      m_sel = m_sel & ~(64'hFF << (8 * sel_wr_grp));
      m_sel = m_sel | (64'(sel_wr_code) << (8 * sel_wr_grp));
      m_sel[63] = 1'b1;
    end
    if (typ_wr_en && int'(typ_wr_idx) < NG) m_typ[typ_wr_idx] = int'(typ_wr_grp);
  endtask

  task automatic tick(input string tag);
    #1;
    chk("R3 cnt_inc", cnt_inc, exp_inc());
    model_step();
    @(posedge clk); @(negedge clk);
    chk("R2 sel_q", sel_q, m_sel);
    chk("R11 typ_q", typ_q, pack_typ());
    chk("R10 rsp_valid", rsp_valid, m_rv);
    chk({tag, " rsp_grant"}, rsp_grant, m_rg);
    chk({tag, " rsp_idx"}, rsp_idx, m_ri);
    sel_wr_en = 0; typ_wr_en = 0; req_valid = 0; rel_valid = 0;
  endtask

  task automatic rnd_raw(); evt_raw = {$urandom, $urandom, $urandom, $urandom}; endtask
  task automatic do_req(input int id, input string tag);
    req_valid = 1; req_id = IW'(id); tick(tag);
  endtask
  task automatic do_rel(input int ix);
    rel_valid = 1; rel_idx = XW'(ix); tick("R9");
  endtask
  task automatic do_typ(input int ix, input int g);
    typ_wr_en = 1; typ_wr_idx = XW'(ix); typ_wr_grp = 4'(g); rnd_raw(); tick("R11");
  endtask
  task automatic do_sel(input int g, input int c);
    sel_wr_en = 1; sel_wr_grp = 3'(g); sel_wr_code = 8'(c); rnd_raw(); tick("R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog R10 run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_sel = '0; m_rv = 0; m_rg = 0; m_ri = 0;
    for (int i = 0; i < NG; i++) begin m_typ[i] = 0; m_own[i] = 0; end
    for (int i = 0; i <= NG; i++) m_busy[i] = 0;
    for (int i = 0; i < 8; i++) m_gbusy[i] = 0;
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sel_q", sel_q, 0);
    chk("R1 typ_q", typ_q, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    evt_raw = '1; #1;
    chk("R1 cnt_inc", cnt_inc, 0);
    rst_n = 1;

    do_typ(0, 0); do_typ(1, 3); do_typ(2, 7); do_typ(3, 9);
    do_typ(5, 2);
    for (int n = 0; n < 4; n++) begin rnd_raw(); tick("R3"); end
    do_sel(0, 2); do_sel(3, 5); do_sel(7, 1); do_sel(3, 20);
    for (int n = 0; n < 6; n++) begin rnd_raw(); tick("R3"); end
    do_sel(3, 15); do_sel(7, 8'h7F);
    for (int n = 0; n < 6; n++) begin rnd_raw(); tick("R3"); end
    do_typ(3, 3);
    for (int n = 0; n < 4; n++) begin rnd_raw(); tick("R3"); end

    do_req(16'h021, "R4");
    do_req(16'h032, "R4");
    do_req(16'h041, "R5");
    do_req(16'h0FE, "R7");
    do_req(16'h0FE, "R7");
    do_req(16'h1003, "R8");
    do_req(16'h009, "R8");
    do_req(16'h013, "R4");
    do_req(16'h024, "R4");
    do_req(16'h025, "R6");
    do_rel(1);
    do_req(16'h052, "R9");
    do_rel(4);
    do_req(16'h0FE, "R9");
    rel_valid = 1; rel_idx = 0; do_req(16'h061, "R9");
    do_req(16'h061, "R9");
    do_rel(0); do_rel(0);
    do_req(16'h071, "R9");
    do_rel(7);
    do_req(16'h0F7, "R6");

    repeat (2) tick("R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule